// File: doc/BRIEF.md
# Multiplexed Host Memory-Access Slave Port

This block gives an external host direct access to a target's internal program store and data store over one 16-bit bus. The bus carries addresses and data at different times. An active-low select, an address-latch strobe and active-low read and write strobes decide what each bus value means. The host first sends a start address, together with a memory-type bit, in a latch cycle. Every later read or write works at the current address, and the address advances by itself once a whole word has moved. A burst therefore needs only one latch cycle.

Program words are 24 bits wide, so each one crosses the bus in two halves. The upper sixteen bits go first. The low byte follows in bits 7:0. Data words are 16 bits and take one access. After each accepted write the active-low acknowledge goes high for one clock, which stands for the internal memory cycle. A careful host waits for the acknowledge to be low before every access. The boot phase ends when the host completes a write to program address zero, and the block then raises a sticky boot-complete flag.

The controller is a four-state machine. Its states are:
- `PS_READY_UPPER`: ready, and the next program access is the upper half.
- `PS_READY_LOWER`: ready, and the next program access is the low byte.
- `PS_STALL_UPPER`: acknowledge high after a write; the upper half comes next.
- `PS_STALL_LOWER`: acknowledge high after a write; the low byte comes next.

Its transitions are:
- A latch from either ready state goes to `PS_READY_UPPER`.
- From `PS_READY_UPPER`:
  - a program write goes to `PS_STALL_LOWER`;
  - a data write goes to `PS_STALL_UPPER`;
  - a program read goes to `PS_READY_LOWER`;
  - a data read stays in `PS_READY_UPPER`.
- From `PS_READY_LOWER`:
  - a write goes to `PS_STALL_UPPER`;
  - a read goes to `PS_READY_UPPER`.
- Each stall state returns after one clock to the ready state with the same half.

Top module: `hmp_slave_port`

## Requirements
- R1: After reset, `ack_n` is 0, `boot_done` is 0 and `ad_out` is 0x0000. The address and memory type are both 0, which selects program address 0.
- R2: A cycle with `sel_n` low and `latch` high loads the address from `ad_in[13:0]` and the memory type from `ad_in[14]` (0 selects program memory, 1 selects data memory). It ignores `ad_in[15]` and sets the next program half to upper.
- R3: A cycle with `latch` high is only an address latch, even when `wr_n` or `rd_n` is also low. No memory is written.
- R4: A data-memory write stores the 16-bit `ad_in` at the current address in one access, and the address then rises by one.
- R5: A program-memory write takes two accesses. The first holds `ad_in` as bits 23:8. The second stores {held, `ad_in[7:0]`} and ignores `ad_in[15:8]`. The address rises by one only after the second access.
- R6: A read places its result on `ad_out` in the clock after it is accepted. A program word reads as bits 23:8 first and then {8'h00, bits 7:0}. A data word reads in one access. The address steps on the same rule as for writes, and reads do not raise `ack_n`.
- R7: Each accepted write drives `ack_n` high for exactly one clock. Any access presented while `ack_n` is high is ignored.
- R8: `boot_done` rises in the clock after the low-byte write that completes program address 0x0000, and it stays high until reset. An upper-half write alone, or any data write, does not set it.
- R9: The 14-bit address wraps from 0x3FFF to 0x0000.
- R10: With `sel_n` high, the strobes have no effect.
- R11: If `wr_n` and `rd_n` are both low without `latch`, the cycle is a write, and `ad_out` keeps its value.
- R12: A latch between the two halves of a program word discards the held upper half. The next program write is then an upper half again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low port select |
| latch | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 16 | Address or data from the host |
| ad_out | output | 16 | Registered read data to the host |
| ack_n | output | 1 | Active-low acknowledge: low means ready |
| boot_done | output | 1 | Sticky flag, set once program address 0 is written |

## Verification
A wrong half-word state appears at once as swapped or misplaced bytes in the next program read. It also appears as an address that moves one word early or late, which the next read after a latch exposes. A lost stall shows as `ack_n` staying low in the clock after a write. A stuck stall shows as a second high clock. A reference model is compared with `ack_n`, `ad_out` and `boot_done` on every clock, so any divergence is caught in the cycle it reaches a port. Damage to stored words shows up when those words are read back.

// File: rtl/hmp_pkg.sv
`timescale 1ns/1ps
package hmp_pkg;
    localparam int ADDR_W = 14;
    localparam int BUS_W  = 16;
    localparam int PM_W   = 24;
    localparam int LOW_W  = PM_W - BUS_W;

    typedef enum logic [1:0] {
        PS_READY_UPPER = 2'd0,
        PS_READY_LOWER = 2'd1,
        PS_STALL_UPPER = 2'd2,
        PS_STALL_LOWER = 2'd3
    } port_state_t;

    typedef enum logic {
        MEM_PROG = 1'b0,
        MEM_DATA = 1'b1
    } mem_sel_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LATCH = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READ  = 2'd3
    } access_t;
endpackage

// File: rtl/hmp_access_decode.sv
`timescale 1ns/1ps
module hmp_access_decode
    import hmp_pkg::*;
(
    input  logic    sel_n,
    input  logic    latch,
    input  logic    rd_n,
    input  logic    wr_n,
    input  logic    stalled,
    output access_t acc
);
    always_comb begin
        acc = ACC_NONE;
        if (!sel_n && !stalled) begin
            if (latch)      acc = ACC_LATCH;
            else if (!wr_n) acc = ACC_WRITE;
            else if (!rd_n) acc = ACC_READ;
        end
    end
endmodule

// File: rtl/hmp_addr_ctrl.sv
`timescale 1ns/1ps
module hmp_addr_ctrl
    import hmp_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  mem_sel_t      load_sel,
    input  logic          inc,
    output logic [AW-1:0] addr_q,
    output mem_sel_t      sel_q
);
    localparam logic [AW-1:0] STEP = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= MEM_PROG;
        end else if (load) begin
            addr_q <= load_addr;
            sel_q  <= load_sel;
        end else if (inc) begin
            addr_q <= addr_q + STEP;
        end
    end
endmodule

// File: rtl/hmp_word_pack.sv
`timescale 1ns/1ps
module hmp_word_pack
    import hmp_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int WW = PM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_upper,
    input  logic [BW-1:0] din,
    output logic [WW-1:0] word
);
    localparam int LW = WW - BW;

    logic [BW-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         upper_q <= '0;
        else if (cap_upper) upper_q <= din;
    end

    assign word = {upper_q, din[LW-1:0]};
endmodule

// File: rtl/hmp_mem.sv
`timescale 1ns/1ps
module hmp_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/hmp_slave_port.sv
`timescale 1ns/1ps
module hmp_slave_port
    import hmp_pkg::*;
#(
    parameter int PM_DEPTH = 64,
    parameter int DM_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              latch,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ack_n,
    output logic              boot_done
);
    localparam int PM_IW = $clog2(PM_DEPTH);
    localparam int DM_IW = $clog2(DM_DEPTH);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    port_state_t state_q, state_d;
    access_t     acc;
    mem_sel_t    msel;
    logic [ADDR_W-1:0] addr_q;
    logic [PM_W-1:0]   pm_wdata, pm_rdata;
    logic [BUS_W-1:0]  dm_rdata;
    logic stalled, lower_half, is_prog;
    logic do_latch, do_write, do_read, step, pm_we, dm_we, cap_upper;

    assign stalled    = (state_q == PS_STALL_UPPER) || (state_q == PS_STALL_LOWER);
    assign lower_half = (state_q == PS_READY_LOWER);
    assign is_prog    = (msel == MEM_PROG);

    hmp_access_decode u_dec (
        .sel_n   (sel_n),
        .latch   (latch),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .stalled (stalled),
        .acc     (acc)
    );

    assign do_latch  = (acc == ACC_LATCH);
    assign do_write  = (acc == ACC_WRITE);
    assign do_read   = (acc == ACC_READ);
    assign step      = (do_write || do_read) && (!is_prog || lower_half);
    assign pm_we     = do_write && is_prog && lower_half;
    assign dm_we     = do_write && !is_prog;
    assign cap_upper = do_write && is_prog && !lower_half;

    hmp_addr_ctrl #(.AW(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_latch),
        .load_addr (ad_in[ADDR_W-1:0]),
        .load_sel  (mem_sel_t'(ad_in[ADDR_W])),
        .inc       (step),
        .addr_q    (addr_q),
        .sel_q     (msel)
    );

    hmp_word_pack #(.BW(BUS_W), .WW(PM_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_upper (cap_upper),
        .din       (ad_in),
        .word      (pm_wdata)
    );

    hmp_mem #(.DEPTH(PM_DEPTH), .WIDTH(PM_W), .IW(PM_IW)) u_pm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pm_we),
        .idx   (addr_q[PM_IW-1:0]),
        .wdata (pm_wdata),
        .rdata (pm_rdata)
    );

    hmp_mem #(.DEPTH(DM_DEPTH), .WIDTH(BUS_W), .IW(DM_IW)) u_dm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dm_we),
        .idx   (addr_q[DM_IW-1:0]),
        .wdata (ad_in),
        .rdata (dm_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_READY_UPPER;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_READY_UPPER: begin
                if (do_latch)      state_d = PS_READY_UPPER;
                else if (do_write) state_d = is_prog ? PS_STALL_LOWER : PS_STALL_UPPER;
                else if (do_read)  state_d = is_prog ? PS_READY_LOWER : PS_READY_UPPER;
            end
            PS_READY_LOWER: begin
                if (do_latch)      state_d = PS_READY_UPPER;
                else if (do_write) state_d = PS_STALL_UPPER;
                else if (do_read)  state_d = PS_READY_UPPER;
            end
            PS_STALL_UPPER: state_d = PS_READY_UPPER;
            PS_STALL_LOWER: state_d = PS_READY_LOWER;
            default:        state_d = PS_READY_UPPER;
        endcase
    end

    // outputs
    assign ack_n = stalled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_out    <= '0;
            boot_done <= 1'b0;
        end else begin
            if (do_read) begin
                if (!is_prog)        ad_out <= dm_rdata;
                else if (lower_half) ad_out <= {{(BUS_W-LOW_W){1'b0}}, pm_rdata[LOW_W-1:0]};
                else                 ad_out <= pm_rdata[PM_W-1:LOW_W];
            end
            if (pm_we && addr_q == '0) boot_done <= 1'b1;
        end
    end

    // assertions
    assert_ack_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |=> !ack_n);
    assert_write_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> ack_n);
    assert_stall_holds_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |=> $stable(addr_q));
    assert_boot_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
    assert_boot_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_done) |-> ($past(pm_we) && $past(addr_q) == '0));
    assert_upper_no_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_upper |=> $stable(addr_q));
    assert_data_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |=> addr_q == $past(addr_q) + ONE);
    assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !ack_n) |=> ($stable(addr_q) && $stable(ad_out)));
endmodule

// File: tb/hmp_slave_port_bench.sv
`timescale 1ns/1ps
module hmp_slave_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        latch = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ack_n;
    logic        boot_done;

    always #2 clk = ~clk;

    hmp_slave_port u_hmp_slave_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .latch(latch),
        .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out),
        .ack_n(ack_n), .boot_done(boot_done)
    );

    int    nvec = 0;
    int    nfail = 0;
    string cur_req = "R1";
    bit    cmp_en = 0;

    // reference model
    int m_addr = 0, m_hold = 0, m_out = 0;
    bit m_data = 0, m_lo = 0, m_stall = 0, m_boot = 0;
    int pm_m [64];
    int dm_m [64];

    task automatic chk(input int act, input int exp, input string tag);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_hold = 0; m_out = 0; m_data = 0;
            m_lo = 0; m_stall = 0; m_boot = 0;
            for (int i = 0; i < 64; i++) begin pm_m[i] = 0; dm_m[i] = 0; end
            cmp_en = 1;
        end else if (m_stall) begin
            m_stall = 0;
        end else if (!sel_n) begin
            if (latch) begin
                m_addr = ad_in & 16'h3FFF;
                m_data = ad_in[14];
                m_lo = 0;
            end else if (!wr_n) begin
                m_stall = 1;
                if (m_data) begin
                    dm_m[m_addr % 64] = ad_in;
                    m_addr = (m_addr + 1) & 16'h3FFF;
                end else if (!m_lo) begin
                    m_hold = ad_in;
                    m_lo = 1;
                end else begin
                    pm_m[m_addr % 64] = (m_hold << 8) | (ad_in & 255);
                    if (m_addr == 0) m_boot = 1;
                    m_addr = (m_addr + 1) & 16'h3FFF;
                    m_lo = 0;
                end
            end else if (!rd_n) begin
                if (m_data) begin
                    m_out = dm_m[m_addr % 64];
                    m_addr = (m_addr + 1) & 16'h3FFF;
                end else if (!m_lo) begin
                    m_out = (pm_m[m_addr % 64] >> 8) & 16'hFFFF;
                    m_lo = 1;
                end else begin
                    m_out = pm_m[m_addr % 64] & 255;
                    m_addr = (m_addr + 1) & 16'h3FFF;
                    m_lo = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(ad_out, m_out, cur_req);
            chk(ack_n, m_stall, cur_req);
            chk(boot_done, m_boot, cur_req);
        end
    end

    task automatic bus_op(input bit l, input bit w, input bit r,
                          input logic [15:0] d, input bit wait_ack);
        if (wait_ack) while (ack_n) @(negedge clk);
        sel_n = 1'b0; latch = l; wr_n = !w; rd_n = !r; ad_in = d;
        @(negedge clk);
        sel_n = 1'b1; latch = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic lat(input logic [15:0] d); bus_op(1, 0, 0, d, 1); endtask
    task automatic wr(input logic [15:0] d);  bus_op(0, 1, 0, d, 1); endtask
    task automatic rd_chk(input int exp, input string tag);
        bus_op(0, 0, 1, 16'h0000, 1);
        chk(ad_out, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(ack_n, 0, "R1"); chk(boot_done, 0, "R1"); chk(ad_out, 0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R5 program writes, R6 program reads
        cur_req = "R5";
        lat(16'h0001);
        wr(16'h1234); wr(16'h0056);
        wr(16'hABCD); wr(16'hFF78);
        cur_req = "R6";
        lat(16'h0001);
        rd_chk(16'h1234, "R6"); rd_chk(16'h0056, "R6");
        rd_chk(16'hABCD, "R6"); rd_chk(16'h0078, "R5");

        // R4 data memory
        cur_req = "R4";
        lat(16'h4005); wr(16'hBEEF); wr(16'hCAFE);
        lat(16'h4005);
        rd_chk(16'hBEEF, "R4"); rd_chk(16'hCAFE, "R4");
        chk(boot_done, 0, "R8");

        // R2 bit 15 ignored
        cur_req = "R2";
        lat(16'hC005); rd_chk(16'hBEEF, "R2");

        // R3 latch with write strobe is latch only
        cur_req = "R3";
        lat(16'h4007);
        bus_op(1, 1, 0, 16'h4005, 1);
        rd_chk(16'hBEEF, "R3");
        lat(16'h4007); rd_chk(16'h0000, "R3");

        // R12 latch discards upper half
        cur_req = "R12";
        lat(16'h0003); wr(16'h1111);
        lat(16'h0003); wr(16'h2222); wr(16'h0033);
        lat(16'h0003);
        rd_chk(16'h2222, "R12"); rd_chk(16'h0033, "R12");

        // R7 stall ignores access
        cur_req = "R7";
        lat(16'h400A); wr(16'h0AAA);
        chk(ack_n, 1, "R7");
        bus_op(0, 1, 0, 16'h0BBB, 0);
        chk(ack_n, 0, "R7");
        wr(16'h0CCC);
        lat(16'h400A);
        rd_chk(16'h0AAA, "R7"); rd_chk(16'h0CCC, "R7");

        // R10 deselected strobes
        cur_req = "R10";
        lat(16'h4014); wr(16'h5555); wr(16'h6666);
        lat(16'h4014);
        wr_n = 1'b0; ad_in = 16'h7777;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        rd_chk(16'h5555, "R10");

        // R11 read and write together
        cur_req = "R11";
        lat(16'h401E);
        bus_op(0, 1, 1, 16'h3131, 1);
        chk(ad_out, 16'h5555, "R11");
        lat(16'h401E); rd_chk(16'h3131, "R11");

        // R9 wrap
        cur_req = "R9";
        lat(16'h7FFF); wr(16'h7F7F); wr(16'h0101);
        lat(16'h4000); rd_chk(16'h0101, "R9");
        lat(16'h403F); rd_chk(16'h7F7F, "R9");
        chk(boot_done, 0, "R8");

        // R8 boot detection
        cur_req = "R8";
        lat(16'h0000); wr(16'h00C0);
        chk(boot_done, 0, "R8");
        wr(16'h0001);
        chk(boot_done, 1, "R8");
        wr(16'h4444); wr(16'h0044);
        repeat (2) @(negedge clk);
        chk(boot_done, 1, "R8");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule